// File: doc/BRIEF.md
# Triggered Logic Analyzer Capture Core

This core is an on-chip capture engine for debugging a design from the inside. A user data bus is sampled into a synchronous-read RAM used as a ring buffer. Sampling happens only on clock cycles where a qualifier input is high. All control, trigger bookkeeping and readout run on every cycle of the same free-running clock.

The core is armed in one of two ways. A local `run` input can arm it, or a one-cycle `host_arm` pulse can arm it while `run` stays low. Once armed, the buffer keeps overwriting its oldest entries. A trigger is accepted on the first qualified sample that matches a masked compare value, but only after a minimum number of pre-trigger samples has been stored. A runtime-selected number of post-trigger samples then follows. The post count is capped so that the oldest retained pre-trigger samples are never overwritten.

When capture completes, `done` rises and the buffer is streamed out from oldest to newest on a byte-wide valid/ready port, with the least significant byte of each sample first. After the last byte is accepted, the core returns to idle.

Top module: `la_capture_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the core goes idle: `armed`, `triggered`, `done` and `rd_valid` are all low one edge later, and this also aborts a capture that is in progress.
- R2: In idle, `run` high or `host_arm` high at a rising edge arms the core, and `armed` is high after that edge.
- R3: Samples are stored, and tested for the trigger, only on cycles with `cqual` high. Data on unqualified cycles never triggers. All control and readout ignore `cqual`, so qualified data presented while idle or reading out does not change the stored samples.
- R4: The trigger condition is `((data_in ^ trig_value) & trig_mask) == 0` on a qualified sample while the core is armed. On the edge that stores that sample, `armed` falls and `triggered` rises.
- R5: A trigger is accepted only if at least `TRIG_POS` qualified samples were stored since arming, not counting the matching sample itself. Matches that come earlier leave the core armed.
- R6: Each qualified sample occupies its own buffer entry, including a value that is present for only one qualified cycle.
- R7: Capture ends on the edge that stores the `post_len`-th qualified sample after the trigger sample, or on the trigger sample itself when `post_len` is 0. `done` is high after that edge.
- R8: The number of post-trigger samples is limited to `DEPTH-1-TRIG_POS`, even when `post_len` asks for more.
- R9: Readout sends min(`DEPTH`, samples stored since arming) samples, oldest first. Each sample goes out as ceil(`DATA_W`/8) bytes, least significant byte first, and one byte transfers on each cycle where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_valid` and `rd_data` hold.
- R10: After the last byte is accepted, `done`, `triggered` and `armed` are all low, and the core can be armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| cqual | input | 1 | Sample qualifier |
| run | input | 1 | Local arm request |
| host_arm | input | 1 | Host arm request (single-cycle pulse) |
| data_in | input | DATA_W | Bus under observation |
| trig_value | input | DATA_W | Trigger compare value |
| trig_mask | input | DATA_W | Trigger compare mask, 1 = bit compared |
| post_len | input | $clog2(DEPTH)+1 | Requested post-trigger sample count |
| armed | output | 1 | Armed and waiting for the trigger |
| triggered | output | 1 | Trigger seen; high until readout ends |
| done | output | 1 | Capture complete, readout in progress |
| rd_data | output | 8 | Readout byte |
| rd_valid | output | 1 | Readout byte valid |
| rd_ready | input | 1 | Readout byte accepted |

## Verification
`armed` is due one edge after the arming pulse. `triggered` is due on the same edge that writes the trigger sample, and `done` on the edge that writes the final post-trigger sample. The first readout byte appears two edges after `done` rises, because of the RAM read and the load into the shift register. The bench changes inputs 1 ns after each rising edge and checks the status outputs at that point, after the edge it predicted. A monitor compares readout bytes at each falling edge against a queue that the driver filled from its own model of which samples must survive. The same monitor checks that a stalled byte is held.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_POST,
        ST_RADDR,
        ST_RLOAD,
        ST_RSEND
    } la_state_e;

    function automatic int unsigned la_bytes(input int unsigned width);
        return (width + 7) / 8;
    endfunction

    function automatic int unsigned la_post_cap(input int unsigned depth, input int unsigned pre);
        return depth - 1 - pre;
    endfunction

endpackage

// File: rtl/la_trig_match.sv
module la_trig_match #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] mask,
    output logic              hit
);
    always_comb begin
        hit = ((sample ^ value) & mask) == '0;
    end
endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/la_ctrl.sv
module la_ctrl
    import la_cap_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 64,
    parameter int TRIG_POS = 32,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cqual,
    input  logic              run,
    input  logic              host_arm,
    input  logic              hit,
    input  logic [CW-1:0]     post_len,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [AW-1:0]     ram_raddr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              armed,
    output logic              triggered,
    output logic              done,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready
);
    localparam int NB  = la_bytes(DATA_W);
    localparam int SW  = NB * 8;
    localparam int BW  = (NB > 1) ? $clog2(NB) : 1;
    localparam int CAP = la_post_cap(DEPTH, TRIG_POS);

    la_state_e      state_q;
    logic [AW-1:0]  wptr_q, rptr_q, wptr_n;
    logic [CW-1:0]  fill_q, fill_n, pre_q, post_q, lim_q, left_q;
    logic [SW-1:0]  sh_q;
    logic [BW-1:0]  byte_q;
    logic           pre_ok, fire, finish;

    always_comb begin
        ram_we    = (state_q == ST_PRE || state_q == ST_POST) && cqual;
        ram_waddr = wptr_q;
        ram_raddr = rptr_q;
        wptr_n    = wptr_q + 1'b1;
        fill_n    = (fill_q == CW'(DEPTH)) ? fill_q : fill_q + 1'b1;
        pre_ok    = pre_q >= CW'(TRIG_POS);
        fire      = (state_q == ST_PRE) && cqual && hit && pre_ok;
        finish    = (fire && lim_q == '0) ||
                    (state_q == ST_POST && cqual && (post_q + 1'b1) == lim_q);
        armed     = state_q == ST_PRE;
        done      = state_q == ST_RADDR || state_q == ST_RLOAD || state_q == ST_RSEND;
        triggered = state_q == ST_POST || done;
        rd_valid  = state_q == ST_RSEND;
        rd_data   = sh_q[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wptr_q  <= '0;
            rptr_q  <= '0;
            fill_q  <= '0;
            pre_q   <= '0;
            post_q  <= '0;
            lim_q   <= '0;
            left_q  <= '0;
            sh_q    <= '0;
            byte_q  <= '0;
        end else begin
            if (ram_we) begin
                wptr_q <= wptr_n;
                fill_q <= fill_n;
            end
            if (finish) begin
                rptr_q  <= wptr_n - fill_n[AW-1:0];
                left_q  <= fill_n;
                state_q <= ST_RADDR;
            end
            case (state_q)
                ST_IDLE: if (run || host_arm) begin
                    state_q <= ST_PRE;
                    wptr_q  <= '0;
                    fill_q  <= '0;
                    pre_q   <= '0;
                    lim_q   <= (post_len > CW'(CAP)) ? CW'(CAP) : post_len;
                end
                ST_PRE: if (cqual) begin
                    if (!pre_ok) pre_q <= pre_q + 1'b1;
                    if (fire) begin
                        post_q <= '0;
                        if (!finish) state_q <= ST_POST;
                    end
                end
                ST_POST: if (cqual) post_q <= post_q + 1'b1;
                ST_RADDR: begin
                    rptr_q  <= rptr_q + 1'b1;
                    state_q <= ST_RLOAD;
                end
                ST_RLOAD: begin
                    sh_q    <= SW'(ram_rdata);
                    byte_q  <= '0;
                    state_q <= ST_RSEND;
                end
                ST_RSEND: if (rd_ready) begin
                    sh_q <= sh_q >> 8;
                    if (byte_q == BW'(NB - 1)) begin
                        left_q  <= left_q - 1'b1;
                        state_q <= (left_q == CW'(1)) ? ST_IDLE : ST_RADDR;
                    end else begin
                        byte_q <= byte_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(run || host_arm));

    // R3
    trig_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> $past(cqual));

    // R5
    trig_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> $past(pre_q) >= CW'(TRIG_POS));

    // R7
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(armed) || $past(triggered)));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R10
    idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> (!armed && !triggered));
endmodule

// File: rtl/la_capture_core.sv
module la_capture_core #(
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 64,
    parameter int TRIG_POS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cqual,
    input  logic                     run,
    input  logic                     host_arm,
    input  logic [DATA_W-1:0]        data_in,
    input  logic [DATA_W-1:0]        trig_value,
    input  logic [DATA_W-1:0]        trig_mask,
    input  logic [$clog2(DEPTH):0]   post_len,
    output logic                     armed,
    output logic                     triggered,
    output logic                     done,
    output logic [7:0]               rd_data,
    output logic                     rd_valid,
    input  logic                     rd_ready
);
    localparam int AW = $clog2(DEPTH);

    logic              hit, ram_we;
    logic [AW-1:0]     ram_waddr, ram_raddr;
    logic [DATA_W-1:0] ram_rdata;

    la_trig_match #(.DATA_W(DATA_W)) u_match (
        .sample(data_in), .value(trig_value), .mask(trig_mask), .hit(hit)
    );

    la_sample_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(data_in),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    la_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TRIG_POS(TRIG_POS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cqual(cqual), .run(run), .host_arm(host_arm),
        .hit(hit), .post_len(post_len), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .armed(armed),
        .triggered(triggered), .done(done), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready)
    );
endmodule

// File: tb/sim_la_capture_core.sv
`timescale 1ns/1ps
module sim_la_capture_core;
    localparam int DW  = 16;
    localparam int DEP = 16;
    localparam int TP  = 4;
    localparam int CWB = $clog2(DEP) + 1;
    localparam int CAP = DEP - 1 - TP;

    logic clk = 0, rst_n = 0, cqual = 0, run = 0, host_arm = 0, rd_ready = 0;
    logic [DW-1:0]  data_in = '0, trig_value = '0, trig_mask = '0;
    logic [CWB-1:0] post_len = '0;
    logic armed, triggered, done, rd_valid;
    logic [7:0] rd_data;

    int total = 0, bad = 0, rcnt = 0;
    bit ready_en = 0, prev_stall = 0;
    logic [7:0] prev_data = '0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    la_capture_core #(.DATA_W(DW), .DEPTH(DEP), .TRIG_POS(TP)) u0 (
        .clk(clk), .rst_n(rst_n), .cqual(cqual), .run(run), .host_arm(host_arm),
        .data_in(data_in), .trig_value(trig_value), .trig_mask(trig_mask),
        .post_len(post_len), .armed(armed), .triggered(triggered), .done(done),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // readout back-pressure pattern
    always @(posedge clk) begin
        #1;
        rcnt++;
        rd_ready = ready_en && (rcnt % 3 != 0);
    end

    // monitor: pops expected bytes as the design hands them over (R6 R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                chk(rd_valid && rd_data == prev_data, "R9", "stalled byte held", rd_data, prev_data);
            prev_stall = rd_valid && !rd_ready;
            prev_data  = rd_data;
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) chk(0, "R9", "unexpected byte", rd_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R6 R9", "read byte", rd_data, e);
                end
            end
        end
    end

    // driver: arms, feeds samples, models the retained window, pushes expected bytes
    task automatic capture(input bit use_host, input int mode, input logic [15:0] base,
                           input logic [15:0] tv, input logic [15:0] tm, input int plen);
        logic [15:0] s [0:255];
        logic [15:0] d;
        int idx = 0, trig = -1, lim, cyc = 0, cnt;
        bit q, fin = 0;
        lim = (plen > CAP) ? CAP : plen;
        trig_value = tv; trig_mask = tm; post_len = CWB'(plen);
        if (use_host) host_arm = 1; else run = 1;
        @(posedge clk); #1;
        host_arm = 0; run = 0;
        chk(armed && !triggered, "R2", "armed after arm pulse", armed, 1);
        while (!fin && cyc < 400) begin
            q = (mode == 0) ? 1'b1 : (cyc % 3 == 1);
            d = q ? base + 16'(idx) : tv;
            cqual = q; data_in = d;
            @(posedge clk); #1;
            if (q) begin
                s[idx] = d;
                if (trig < 0 && idx >= TP && ((d ^ tv) & tm) == 0) begin
                    trig = idx;
                    chk(triggered && !armed, "R4", "trigger flags", {armed, triggered}, 2'b01);
                end else if (trig < 0) begin
                    chk(armed && !triggered, "R5", "still armed before pre count", {armed, triggered}, 2'b10);
                end
                if (trig >= 0 && idx == trig + lim) begin
                    fin = 1;
                    chk(done, (lim < plen) ? "R8" : "R7", "done after last post sample", done, 1);
                    cnt = (idx + 1 > DEP) ? DEP : idx + 1;
                    for (int j = idx + 1 - cnt; j <= idx; j++) begin
                        exp_q.push_back(s[j][7:0]);
                        exp_q.push_back(s[j][15:8]);
                    end
                end
                idx++;
            end else if (trig < 0) begin
                // R3: unqualified data equals the trigger value but must not fire
                chk(armed && !triggered, "R3", "unqualified cycle ignored", {armed, triggered}, 2'b10);
            end
            cyc++;
        end
        // R3: qualified junk during readout must not reach the buffer
        cqual = 1; data_in = 16'hFFFF; ready_en = 1;
        for (int k = 0; k < 600 && done; k++) begin
            @(posedge clk); #1;
        end
        cqual = 0; ready_en = 0;
        chk(!done && !triggered && !armed, "R10", "idle after readout",
            {armed, triggered, done}, 0);
        chk(exp_q.size() == 0, "R9", "bytes left unread", exp_q.size(), 0);
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        #600000;
        chk(0, "WATCHDOG", "run timed out", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!armed && !triggered && !done && !rd_valid, "R1", "reset state",
            {armed, triggered, done, rd_valid}, 0);
        rst_n = 1;
        @(posedge clk); #1;
        // host arm, every cycle qualified, mask 0: fires at the pre limit
        capture(1, 0, 16'h0100, 16'h0000, 16'h0000, 3);
        // run arm, single-cycle qualifier pulses, late exact-match trigger, ring wraps
        capture(0, 1, 16'h1000, 16'h101E, 16'hFFFF, 5);
        // no post samples, nibble-masked trigger
        capture(0, 0, 16'h2000, 16'h0006, 16'h000F, 0);
        // post request beyond the cap
        capture(1, 0, 16'h3000, 16'h0000, 16'h0000, 20);
        // reset aborts an armed capture (R1)
        run = 1;
        @(posedge clk); #1;
        run = 0;
        rst_n = 0;
        @(posedge clk); #1;
        chk(!armed && !triggered && !done, "R1", "reset aborts capture",
            {armed, triggered, done}, 0);
        rst_n = 1;
        @(posedge clk); #1;
        capture(0, 0, 16'h4000, 16'h4009, 16'hFFFF, 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule